// File: doc/BRIEF.md
# Per-Process Commit Heartbeat Monitor

This block watches the stream of retired instructions of a processor core and decides, once per fixed time window, whether each monitored process is still making progress. It keeps one commit counter for each of a small set of process IDs, plus one further counter reserved for the operating system. A process that retires fewer instructions in a window than a programmed minimum is declared hung or crashed. The operating system's own verdict is also driven onto a separate flag.

The checking application programs the minimum instruction count and the window length through a small write port. The same port selects which slots take part in checking and clears hang flags once software has handled them. When a window ends, a sequencer walks the counter array, visiting one slot per clock. It compares the slot's count with the minimum, latches a hang verdict, and restarts the slot's count for the new window.

Top module: `hbm_liveness_mon`

## Requirements
- R1: After reset, every hang bit and the OS hang flag are 0, all slots are disabled, and all counts are 0.
- R2: A commit with PID p, where p < NUM_PROC, counts in slot p. A commit with PID equal to OS_PID counts in the OS slot, which has index NUM_PROC. A commit with any other PID changes nothing.
- R3: Each window lasts WIN cycles. After the last cycle of a window, slots 0 to NUM_PROC are examined in rising index order, one per cycle. An enabled slot whose count for that window is below the threshold has its hang bit set, and every examined slot restarts counting from zero. A count equal to the threshold is healthy.
- R4: A slot whose enable bit is 0 never sets its hang bit.
- R5: A hang bit stays at 1 until a clear write with a 1 in that slot's bit position.
- R6: A slot count saturates at 2^CNT_W-1 instead of wrapping.
- R7: os_hang_o equals the hang bit of the OS slot (bit NUM_PROC of hang_o).
- R8: The config address selects the target: 0 = threshold (low CNT_W bits), 1 = window length (low WIN_W bits; values below NUM_PROC+2 are raised to NUM_PROC+2), 2 = enable mask (bit i for slot i), 3 = write-1-to-clear hang mask. A window-length write restarts the window timer from zero and discards all counts, and any scan in progress stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit_valid | input | 1 | One instruction retired this cycle |
| commit_pid | input | PID_W | Process ID of the retired instruction |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration target (see R8) |
| cfg_wdata | input | CFG_W | Configuration write data |
| hang_o | output | NUM_PROC+1 | Sticky hang bit per slot, OS slot at the top |
| os_hang_o | output | 1 | Operating-system hang flag |

## Verification
On every cycle the assertions check four things. The scan index stays inside the slot array, and hang bits rise only in the cycle after a scan step, at most one per cycle. A disabled slot never raises its bit. A bit falls only after a clear write. Only the bench's scenarios can show that the verdict is arithmetically right: counts against thresholds, saturation at the counter's ceiling, foreign PIDs leaving counts untouched, and a window restart discarding earlier commits. To do this it sweeps thresholds, enable masks and per-slot commit counts over a five-slot, three-bit-counter configuration.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
    typedef enum logic [1:0] {
        CFG_THRESH = 2'd0,
        CFG_WINDOW = 2'd1,
        CFG_ENABLE = 2'd2,
        CFG_CLEAR  = 2'd3
    } cfg_addr_e;
endpackage

// File: rtl/hbm_pid_decode.sv
// Maps a retired instruction's PID onto a one-hot slot hit vector (R2).
module hbm_pid_decode #(
    parameter int NUM_PROC = 4,
    parameter int PID_W    = 8,
    parameter int OS_PID   = 255,
    localparam int SLOTS   = NUM_PROC + 1
) (
    input  logic             commit_valid,
    input  logic [PID_W-1:0] commit_pid,
    output logic [SLOTS-1:0] hit
);
    for (genvar g = 0; g < NUM_PROC; g++) begin : g_proc
        assign hit[g] = commit_valid && (commit_pid == PID_W'(g));
    end
    assign hit[NUM_PROC] = commit_valid && (commit_pid == PID_W'(OS_PID));
endmodule

// File: rtl/hbm_cfg_regs.sv
// Configuration registers (R8).
module hbm_cfg_regs
    import hbm_pkg::*;
#(
    parameter int SLOTS   = 5,
    parameter int CNT_W   = 16,
    parameter int WIN_W   = 16,
    parameter int CFG_W   = 16,
    parameter int DEF_THR = 1,
    parameter int DEF_WIN = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] thr,
    output logic [WIN_W-1:0] win,
    output logic [SLOTS-1:0] en_mask,
    output logic [SLOTS-1:0] clr_mask,
    output logic             restart
);
    localparam logic [WIN_W-1:0] MIN_WIN = WIN_W'(SLOTS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] thr;
        logic [WIN_W-1:0] win;
        logic [SLOTS-1:0] en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [WIN_W-1:0] win_raw;

    always_comb begin
        cfg_d    = cfg_q;
        win_raw  = cfg_wdata[WIN_W-1:0];
        restart  = 1'b0;
        clr_mask = '0;
        if (cfg_we) begin
            unique case (cfg_addr_e'(cfg_addr))
                CFG_THRESH: cfg_d.thr = cfg_wdata[CNT_W-1:0];
                CFG_WINDOW: begin
                    cfg_d.win = (win_raw < MIN_WIN) ? MIN_WIN : win_raw;
                    restart   = 1'b1;
                end
                CFG_ENABLE: cfg_d.en = cfg_wdata[SLOTS-1:0];
                CFG_CLEAR:  clr_mask = cfg_wdata[SLOTS-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.thr <= CNT_W'(DEF_THR);
            cfg_q.win <= (WIN_W'(DEF_WIN) < MIN_WIN) ? MIN_WIN : WIN_W'(DEF_WIN);
            cfg_q.en  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign thr     = cfg_q.thr;
    assign win     = cfg_q.win;
    assign en_mask = cfg_q.en;
endmodule

// File: rtl/hbm_window_seq.sv
// Window timer and slot scan sequencer (R3, R8).
module hbm_window_seq #(
    parameter int SLOTS  = 5,
    parameter int WIN_W  = 16,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIN_W-1:0] win,
    input  logic             restart,
    output logic             scan_valid,
    output logic [IDX_W-1:0] scan_idx
);
    typedef struct packed {
        logic [WIN_W-1:0] tmr;
        logic             act;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.act) begin
            if (seq_q.idx == IDX_W'(SLOTS - 1)) begin
                seq_d.act = 1'b0;
                seq_d.idx = '0;
            end else begin
                seq_d.idx = seq_q.idx + 1'b1;
            end
        end
        if (seq_q.tmr >= win - WIN_W'(1)) begin
            seq_d.tmr = '0;
            seq_d.act = 1'b1;
            seq_d.idx = '0;
        end else begin
            seq_d.tmr = seq_q.tmr + 1'b1;
        end
        if (restart) begin
            seq_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign scan_valid = seq_q.act;
    assign scan_idx   = seq_q.idx;
endmodule

// File: rtl/hbm_slot_array.sv
// Saturating commit counters and sticky hang bits (R3, R4, R5, R6).
module hbm_slot_array #(
    parameter int SLOTS  = 5,
    parameter int CNT_W  = 16,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SLOTS-1:0] hit,
    input  logic             scan_valid,
    input  logic [IDX_W-1:0] scan_idx,
    input  logic [CNT_W-1:0] thr,
    input  logic [SLOTS-1:0] en_mask,
    input  logic [SLOTS-1:0] clr_mask,
    input  logic             restart,
    output logic [SLOTS-1:0] hang
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [SLOTS-1:0][CNT_W-1:0] cur;
        logic [SLOTS-1:0]            hang;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        logic here;
        st_d      = st_q;
        st_d.hang = st_q.hang & ~clr_mask;
        for (int i = 0; i < SLOTS; i++) begin
            here = scan_valid && (scan_idx == IDX_W'(i)) && !restart;
            if (here) begin
                if (en_mask[i] && (st_q.cur[i] < thr)) st_d.hang[i] = 1'b1;
                st_d.cur[i] = '0;
            end
            if (restart) st_d.cur[i] = '0;
            if (hit[i]) begin
                if (here || restart)            st_d.cur[i] = CNT_W'(1);
                else if (st_q.cur[i] != CNT_MAX) st_d.cur[i] = st_q.cur[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hang = st_q.hang;
endmodule

// File: rtl/hbm_liveness_mon.sv
module hbm_liveness_mon #(
    parameter int NUM_PROC = 4,
    parameter int PID_W    = 8,
    parameter int OS_PID   = 255,
    parameter int CNT_W    = 16,
    parameter int WIN_W    = 16,
    parameter int CFG_W    = 16,
    parameter int DEF_THR  = 1,
    parameter int DEF_WIN  = 1000,
    localparam int SLOTS   = NUM_PROC + 1,
    localparam int IDX_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit_valid,
    input  logic [PID_W-1:0] commit_pid,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [SLOTS-1:0] hang_o,
    output logic             os_hang_o
);
    logic [SLOTS-1:0] hit;
    logic [CNT_W-1:0] thr;
    logic [WIN_W-1:0] win;
    logic [SLOTS-1:0] en_mask;
    logic [SLOTS-1:0] clr_mask;
    logic             restart;
    logic             scan_valid;
    logic [IDX_W-1:0] scan_idx;

    hbm_pid_decode #(.NUM_PROC(NUM_PROC), .PID_W(PID_W), .OS_PID(OS_PID)) u_dec (
        .commit_valid(commit_valid), .commit_pid(commit_pid), .hit(hit)
    );

    hbm_cfg_regs #(.SLOTS(SLOTS), .CNT_W(CNT_W), .WIN_W(WIN_W), .CFG_W(CFG_W),
                   .DEF_THR(DEF_THR), .DEF_WIN(DEF_WIN)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .thr(thr), .win(win), .en_mask(en_mask),
        .clr_mask(clr_mask), .restart(restart)
    );

    hbm_window_seq #(.SLOTS(SLOTS), .WIN_W(WIN_W)) u_seq (
        .clk(clk), .rst(rst), .win(win), .restart(restart),
        .scan_valid(scan_valid), .scan_idx(scan_idx)
    );

    hbm_slot_array #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_slots (
        .clk(clk), .rst(rst), .hit(hit), .scan_valid(scan_valid),
        .scan_idx(scan_idx), .thr(thr), .en_mask(en_mask),
        .clr_mask(clr_mask), .restart(restart), .hang(hang_o)
    );

    // R7: the OS verdict is the top slot's hang bit
    assign os_hang_o = hang_o[NUM_PROC];
endmodule

// File: rtl/hbm_liveness_chk.sv
module hbm_liveness_chk #(
    parameter int SLOTS = 5,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [SLOTS-1:0] hang_o,
    input logic [SLOTS-1:0] en_q,
    input logic             scan_valid,
    input logic [IDX_W-1:0] scan_idx,
    input logic             cfg_we,
    input logic [1:0]       cfg_addr
);
    assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
        scan_valid |-> (scan_idx <= IDX_W'(SLOTS - 1)));

    assert_one_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hang_o & ~$past(hang_o)));

    assert_rise_in_scan_R3: assert property (@(posedge clk) disable iff (rst)
        (|(hang_o & ~$past(hang_o))) |-> $past(scan_valid));

    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        ((hang_o & ~$past(hang_o) & ~$past(en_q)) == '0));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (|($past(hang_o) & ~hang_o)) |-> ($past(cfg_we) && ($past(cfg_addr) == 2'd3)));
endmodule

bind hbm_liveness_mon hbm_liveness_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .hang_o(hang_o), .en_q(en_mask),
    .scan_valid(scan_valid), .scan_idx(scan_idx),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr)
);

// File: tb/hbm_liveness_mon_bench.sv
`timescale 1ns/1ps
module hbm_liveness_mon_bench;
    localparam int NP = 4;
    localparam int NS = NP + 1;
    localparam int OSP = 255;
    localparam int CMAX = 7;   // 3-bit counters
    localparam int WIN = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       commit_valid = 1'b0;
    logic [7:0] commit_pid = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [NS-1:0] hang_o;
    logic       os_hang_o;

    int errs = 0;
    int checks = 0;
    int cnt [NS];
    int extra_pid;
    logic [NS-1:0] exp_hang;

    always #2.5 clk = ~clk;

    hbm_liveness_mon #(.NUM_PROC(NP), .PID_W(8), .OS_PID(OSP), .CNT_W(3),
                       .WIN_W(8), .CFG_W(8), .DEF_THR(1), .DEF_WIN(200)) u_hbm_liveness_mon (
        .clk(clk), .rst(rst), .commit_valid(commit_valid), .commit_pid(commit_pid),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hang_o(hang_o), .os_hang_o(os_hang_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // entered and left at a negedge
    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic commit(input logic [7:0] pid);
        commit_valid = 1'b1; commit_pid = pid;
        @(negedge clk);
        commit_valid = 1'b0;
    endtask

    function automatic logic [NS-1:0] model(input int thr, input logic [NS-1:0] en);
        logic [NS-1:0] r;
        for (int s = 0; s < NS; s++) begin
            int c;
            c = (cnt[s] > CMAX) ? CMAX : cnt[s];
            r[s] = en[s] && (c < thr);
        end
        return r;
    endfunction

    // restart a window, send cnt[] commits plus extra foreign ones, wait past the scan
    task automatic run_window(input int thr, input logic [NS-1:0] en, input logic do_clr,
                              input int n_extra);
        int used;
        cfg_write(2'd0, 8'(thr));
        cfg_write(2'd2, 8'(en));
        cfg_write(2'd1, 8'(WIN));
        cfg_write(2'd3, do_clr ? 8'h1f : 8'h00);
        used = 1;
        for (int s = 0; s < NS; s++) begin
            for (int k = 0; k < cnt[s]; k++) begin
                commit((s < NP) ? 8'(s) : 8'(OSP));
                used++;
            end
        end
        for (int k = 0; k < n_extra; k++) begin
            commit(8'(NP + ((extra_pid + k * 37) % (OSP - NP))));
            used++;
        end
        repeat (74 - used) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        logic [NS-1:0] prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset hang", 32'(hang_o), 32'h0);
        chk("R1 reset os flag", 32'(os_hang_o), 32'h0);
        // R1: slots start disabled, so a window with no commits raises nothing
        for (int s = 0; s < NS; s++) cnt[s] = 0;
        extra_pid = 0;
        cfg_write(2'd0, 8'd3);
        cfg_write(2'd1, 8'(WIN));
        repeat (75) @(negedge clk);
        chk("R1 disabled after reset", 32'(hang_o), 32'h0);

        // R3 R4 R7 sweep of thresholds, enables and counts
        for (int sc = 0; sc < 16; sc++) begin
            int thr;
            logic [NS-1:0] en;
            thr = sc % 8;
            en = NS'((sc * 7 + 29) % 32) | NS'(sc == 0 ? 31 : 0);
            for (int s = 0; s < NS; s++) cnt[s] = (sc * 3 + s * 5) % 9;
            extra_pid = sc;
            exp_hang = model(thr, en);
            run_window(thr, en, 1'b1, 2);
            for (int s = 0; s < NS; s++)
                chk($sformatf("R3/R4 sc%0d slot%0d", sc, s), 32'(hang_o[s]), 32'(exp_hang[s]));
            chk($sformatf("R7 os flag sc%0d", sc), 32'(os_hang_o), 32'(exp_hang[NP]));
        end

        // R6 saturation: 10 and 8 commits clamp to 7, which meets threshold 7
        cnt[0] = 10; cnt[1] = 7; cnt[2] = 6; cnt[3] = 8; cnt[4] = 0;
        run_window(7, 5'h1f, 1'b1, 0);
        chk("R6 saturation", 32'(hang_o), 32'h14);

        // R3 boundary: count equal to threshold is healthy
        cnt[0] = 2; cnt[1] = 3; cnt[2] = 4; cnt[3] = 0; cnt[4] = 3;
        run_window(3, 5'h1f, 1'b1, 0);
        chk("R3 equal-threshold boundary", 32'(hang_o), 32'h09);

        // R2 foreign PIDs are ignored: only unmatched commits, all slots hang
        for (int s = 0; s < NS; s++) cnt[s] = 0;
        extra_pid = 5;
        run_window(1, 5'h1f, 1'b1, 30);
        chk("R2 foreign PIDs ignored", 32'(hang_o), 32'h1f);

        // R2 mapping: only slot 2 and the OS slot get commits
        cnt[2] = 1; cnt[4] = 1;
        run_window(1, 5'h1f, 1'b1, 0);
        chk("R2 pid mapping", 32'(hang_o), 32'h0b);
        chk("R7 os flag healthy", 32'(os_hang_o), 32'h0);

        // R5 sticky: a healthy window without clearing keeps the bits
        prev = hang_o;
        for (int s = 0; s < NS; s++) cnt[s] = 5;
        run_window(1, 5'h1f, 1'b0, 0);
        chk("R5 sticky without clear", 32'(hang_o), 32'(prev));
        cfg_write(2'd3, 8'h01);
        chk("R5 partial clear", 32'(hang_o), 32'(prev & 5'h1e));
        cfg_write(2'd3, 8'h1f);
        chk("R5 full clear", 32'(hang_o), 32'h0);

        // R8 window restart discards earlier commits
        cfg_write(2'd0, 8'd3);
        for (int k = 0; k < 5; k++) commit(8'd0);
        for (int s = 0; s < NS; s++) cnt[s] = 3;
        cnt[0] = 0;
        run_window(3, 5'h1f, 1'b1, 0);
        chk("R8 restart clears counts", 32'(hang_o), 32'h01);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule